// File: doc/BRIEF.md
# Banked Internal Data Memory Unit

This block is the 256-byte on-chip scratch memory of a small 8-bit controller, together with the logic that turns each operand reference into a physical byte location. A caller presents one access per cycle. The access can be a register number looked up in the active register bank, a direct byte address, an indirect reference through a pointer register or the stack pointer, or a single-bit address inside the bit window. Push and pop strobes drive the stack, whose pointer this block owns.

Direct and bit references whose address has bit 7 set do not touch this memory. They are flagged for the special-function register space instead. An indirect reference reaches all 256 bytes, so the upper half can only be reached through a pointer. Each access returns the addressed byte and, for bit accesses, the addressed bit one clock after it is requested. The returned value is the content as it was before any write made in the same request.

Top module: `dmem_unit`

## Requirements
- R1: While `rst_n` is low, at a clock edge the stack pointer loads 07h, every memory byte clears to 00h, and `rd_valid` is driven low.
- R2: A register access (`acc_kind` = 0) addresses byte bank*8 + `acc_reg`. The bank is `psw_in[4:3]`.
- R3: A direct access (`acc_kind` = 1) with address 00h–7Fh reads, or with `acc_we` writes, that byte.
- R4: A direct access with address 80h–FFh returns `sfr_sel` = 1 and `rd_data` = 00h, and it leaves the memory unchanged.
- R5: An indirect access (`acc_kind` = 2) uses as its address R0 of the current bank when `acc_reg[1:0]` = 0, R1 when it is 1, and the stack pointer when `acc_reg[1]` = 1. It reaches any of the 256 bytes and never asserts `sfr_sel`.
- R6: A bit access (`acc_kind` = 3) with bit address b < 80h selects byte 20h + b[6:3], bit b[2:0]. It returns that bit on `rd_bit` and the whole byte on `rd_data`. A write stores `acc_wbit` into that bit only.
- R7: A bit access with b ≥ 80h returns `sfr_sel` = 1, `rd_bit` = 0 and `rd_data` = 00h, and it changes no memory byte.
- R8: A push first increments the stack pointer and then writes `acc_wdata` at the new pointer. It produces no result (`rd_valid` low in the next cycle).
- R9: A pop returns the byte at the stack pointer and then decrements the pointer. The pointer wraps modulo 256 in both directions.
- R10: One operation runs per cycle. `push` wins over `pop`, and `pop` wins over `acc_valid`. Results appear, with `rd_valid` high, exactly one cycle after a pop or access request, and they show the memory content from before that request's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request |
| acc_kind | input | 2 | 0 register, 1 direct, 2 indirect, 3 bit |
| acc_addr | input | 8 | Direct byte address or bit address |
| acc_reg | input | 3 | Register number, or pointer select for indirect |
| acc_we | input | 1 | Write enable for the access |
| acc_wdata | input | 8 | Byte write data, also push data |
| acc_wbit | input | 1 | Bit write value |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| psw_in | input | 8 | Status register; bits 4:3 select the bank |
| rd_valid | output | 1 | Result valid |
| rd_data | output | 8 | Returned byte |
| rd_bit | output | 1 | Returned bit for bit accesses |
| sfr_sel | output | 1 | Access belongs to the special-function space |
| sp_out | output | 8 | Current stack pointer |

## Verification
The bench writes the same register number under two banks and reads both back directly. A design that ignored the bank bits would return one value twice. Direct and bit writes above 7Fh are followed by indirect reads of the same location. A design that failed to divert them to the special-function space would show corrupted bytes. Bit writes are followed by byte reads of the window byte, which exposes a design that clobbers neighbouring bits or uses the wrong byte offset. The stack is popped through zero and pushed back across FFh to catch pointer wrap errors, and push, pop and access are raised together to catch a wrong priority order.

// File: rtl/dmem_pkg.sv
// Shared definitions for the banked data memory unit.
// Assumes an 8-bit data path; the access-kind encoding is fixed at 2 bits.
package dmem_pkg;
    typedef enum logic [1:0] {
        KIND_REG = 2'd0,
        KIND_DIR = 2'd1,
        KIND_IND = 2'd2,
        KIND_BIT = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/dmem_resolve.sv
// Address resolver: turns an access request into a physical byte index,
// a bit position and a special-function-space flag.
// Assumes the pointer value for indirect accesses is read back from the
// array through ptr_idx/ptr_val in the same cycle (combinational path).
module dmem_resolve
    import dmem_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int REG_W    = 3,
    parameter int BANK_W   = 2,
    parameter int BIT_BASE = 32
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  reg_no,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] ptr_val,
    output logic [ADDR_W-1:0] ptr_idx,
    output logic [ADDR_W-1:0] phys,
    output logic [2:0]        bit_pos,
    output logic              sfr_hit,
    output logic              is_bit
);
    localparam int BYTE_SEL_W = ADDR_W - 4;

    logic [ADDR_W-1:0] bank_base;
    logic [ADDR_W-1:0] bit_byte;

    // Base address of the active bank and the pointer register index.
    always_comb begin
        bank_base = ADDR_W'(bank) << REG_W;
        ptr_idx   = bank_base + ADDR_W'(reg_no[0]);
        bit_byte  = ADDR_W'(BIT_BASE) + ADDR_W'(addr[BYTE_SEL_W+2:3]);
    end

    // Select the physical location for each access kind.
    always_comb begin
        phys    = '0;
        bit_pos = '0;
        sfr_hit = 1'b0;
        is_bit  = 1'b0;
        unique case (acc_kind_e'(kind))
            KIND_REG: phys = bank_base + ADDR_W'(reg_no);
            KIND_DIR: begin
                phys    = addr;
                sfr_hit = addr[ADDR_W-1];
            end
            KIND_IND: phys = reg_no[1] ? sp : ptr_val;
            KIND_BIT: begin
                phys    = bit_byte;
                bit_pos = addr[2:0];
                sfr_hit = addr[ADDR_W-1];
                is_bit  = 1'b1;
            end
            default: phys = '0;
        endcase
    end
endmodule

// File: rtl/dmem_stack.sv
// Stack pointer register: pre-increment on push, post-decrement on pop.
// Assumes the caller has already resolved push/pop priority (never both).
module dmem_stack #(
    parameter int ADDR_W   = 8,
    parameter int SP_RESET = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_push,
    input  logic              do_pop,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] sp_inc
);
    assign sp_inc = sp + 1'b1;

    // Update the pointer; arithmetic wraps at the address width.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= ADDR_W'(SP_RESET);
        else if (do_push)
            sp <= sp_inc;
        else if (do_pop)
            sp <= sp - 1'b1;
    end
endmodule

// File: rtl/dmem_array.sv
// Storage: DEPTH bytes in flops with one masked write port and two
// combinational read ports. Assumes at most one write per cycle.
module dmem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_mask,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Clear on reset, otherwise merge masked write data into one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= '0;
        end else if (wr_en) begin
            cells[wr_addr] <= (cells[wr_addr] & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    assign ra_data = cells[ra_addr];
    assign rb_data = cells[rb_addr];
endmodule

// File: rtl/dmem_unit.sv
// Banked internal data memory unit: register, direct, indirect, bit and
// stack accesses onto a 256-byte array; results are registered (1 cycle).
// Assumes push > pop > access priority when strobes coincide.
module dmem_unit
    import dmem_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int REG_W    = 3,
    parameter int BANK_W   = 2,
    parameter int BANK_LSB = 3,
    parameter int BIT_BASE = 32,
    parameter int SP_RESET = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [REG_W-1:0]  acc_reg,
    input  logic              acc_we,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_wbit,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] psw_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit,
    output logic              sfr_sel,
    output logic [ADDR_W-1:0] sp_out
);
    logic              do_push, do_pop, do_acc;
    logic [ADDR_W-1:0] sp, sp_inc;
    logic [ADDR_W-1:0] ptr_idx, phys, rd_addr, wr_addr;
    logic [DATA_W-1:0] ptr_val, cell_q, wr_data, wr_mask;
    logic [2:0]        bit_pos;
    logic              sfr_hit, is_bit, wr_en;

    // Arbitrate one operation per cycle.
    always_comb begin
        do_push = push;
        do_pop  = pop && !push;
        do_acc  = acc_valid && !push && !pop;
    end

    dmem_resolve #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .BANK_W(BANK_W), .BIT_BASE(BIT_BASE)
    ) u_res (
        .kind(acc_kind), .addr(acc_addr), .reg_no(acc_reg),
        .bank(psw_in[BANK_LSB+BANK_W-1:BANK_LSB]), .sp(sp),
        .ptr_val(ptr_val), .ptr_idx(ptr_idx), .phys(phys),
        .bit_pos(bit_pos), .sfr_hit(sfr_hit), .is_bit(is_bit)
    );

    dmem_stack #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_sp (
        .clk(clk), .rst_n(rst_n), .do_push(do_push), .do_pop(do_pop),
        .sp(sp), .sp_inc(sp_inc)
    );

    // Build the single write request: push data, byte write or bit merge.
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = phys;
        wr_data = acc_wdata;
        wr_mask = '1;
        rd_addr = do_pop ? sp : phys;
        if (do_push) begin
            wr_en   = 1'b1;
            wr_addr = sp_inc;
        end else if (do_acc && acc_we && !sfr_hit) begin
            wr_en = 1'b1;
            if (is_bit) begin
                wr_mask = DATA_W'(1) << bit_pos;
                wr_data = {DATA_W{acc_wbit}};
            end
        end
    end

    dmem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask),
        .ra_addr(ptr_idx), .ra_data(ptr_val),
        .rb_addr(rd_addr), .rb_data(cell_q)
    );

    // Register the result of a pop or an access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_bit   <= 1'b0;
            sfr_sel  <= 1'b0;
        end else begin
            rd_valid <= do_pop || do_acc;
            sfr_sel  <= do_acc && sfr_hit;
            rd_data  <= (do_acc && sfr_hit) ? '0 : cell_q;
            rd_bit   <= do_acc && is_bit && !sfr_hit && cell_q[bit_pos];
        end
    end

    assign sp_out = sp;
endmodule

// File: rtl/dmem_unit_chk.sv
// Protocol checker for dmem_unit, attached by bind below.
module dmem_unit_chk #(
    parameter int ADDR_W   = 8,
    parameter int SP_RESET = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [1:0]        acc_kind,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              push,
    input logic              pop,
    input logic              rd_valid,
    input logic              sfr_sel,
    input logic [ADDR_W-1:0] sp_out
);
    // R1
    sp_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (sp_out == ADDR_W'(SP_RESET)) && !rd_valid);
    // R8
    sp_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> sp_out == ADDR_W'($past(sp_out) + 1));
    // R9
    sp_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> sp_out == ADDR_W'($past(sp_out) - 1));
    // R10
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(sp_out));
    // R10
    no_result_on_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !rd_valid);
    // R10
    result_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && (pop || acc_valid)) |=> rd_valid);
    // R4
    sfr_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !push && !pop && acc_kind == 2'd1 && acc_addr[ADDR_W-1])
        |=> sfr_sel);
    // R5
    ind_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !push && !pop && acc_kind == 2'd2) |=> !sfr_sel);
endmodule

bind dmem_unit dmem_unit_chk #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .push(push), .pop(pop), .rd_valid(rd_valid),
    .sfr_sel(sfr_sel), .sp_out(sp_out)
);

// File: tb/sim_dmem_unit.sv
`timescale 1ns/1ps
module sim_dmem_unit;
    localparam real CLK_P = 8.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0, acc_we = 1'b0, acc_wbit = 1'b0;
    logic [1:0] acc_kind = '0;
    logic [7:0] acc_addr = '0, acc_wdata = '0, psw_in = '0;
    logic [2:0] acc_reg = '0;
    logic       push = 1'b0, pop = 1'b0;
    logic       rd_valid, rd_bit, sfr_sel;
    logic [7:0] rd_data, sp_out;

    int n_vec = 0, n_bad = 0;
    logic [7:0] m [256];
    logic [7:0] sp_m;
    logic [7:0] q_data[$];
    logic       q_bit[$];
    logic       q_sfr[$];
    string      q_tag[$];

    always #(CLK_P/2) clk = ~clk;

    dmem_unit u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_addr(acc_addr), .acc_reg(acc_reg), .acc_we(acc_we),
        .acc_wdata(acc_wdata), .acc_wbit(acc_wbit), .push(push), .pop(pop),
        .psw_in(psw_in), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_bit(rd_bit), .sfr_sel(sfr_sel), .sp_out(sp_out)
    );

    // Driver: one operation per call, model updated from the requirements.
    task automatic drive(input logic p, input logic q, input logic av,
                         input logic [1:0] k, input logic [7:0] a,
                         input logic [2:0] r, input logic we,
                         input logic [7:0] wd, input logic wb, input string tag);
        logic [7:0] pa, bank8;
        @(negedge clk);
        push = p; pop = q; acc_valid = av; acc_kind = k; acc_addr = a;
        acc_reg = r; acc_we = we; acc_wdata = wd; acc_wbit = wb;
        bank8 = {3'b0, psw_in[4:3], 3'b0};
        if (p) begin
            sp_m = sp_m + 1; m[sp_m] = wd;
        end else if (q) begin
            q_data.push_back(m[sp_m]); q_bit.push_back(1'b0);
            q_sfr.push_back(1'b0); q_tag.push_back(tag);
            sp_m = sp_m - 1;
        end else if (av) begin
            if ((k == 2'd1 || k == 2'd3) && a[7]) begin
                q_data.push_back(8'h00); q_bit.push_back(1'b0);
                q_sfr.push_back(1'b1);
            end else begin
                case (k)
                    2'd0: pa = bank8 + {5'b0, r};
                    2'd1: pa = a;
                    2'd2: pa = r[1] ? sp_m : m[bank8 + {7'b0, r[0]}];
                    default: pa = 8'h20 + {4'b0, a[6:3]};
                endcase
                q_data.push_back(m[pa]); q_sfr.push_back(1'b0);
                q_bit.push_back(k == 2'd3 ? m[pa][a[2:0]] : 1'b0);
                if (we) begin
                    if (k == 2'd3) m[pa][a[2:0]] = wb;
                    else m[pa] = wd;
                end
            end
            q_tag.push_back(tag);
        end
        @(posedge clk); #1;
        push = 0; pop = 0; acc_valid = 0; acc_we = 0;
    endtask

    task automatic acc(input logic [1:0] k, input logic [7:0] a, input logic [2:0] r,
                       input logic we, input logic [7:0] wd, input logic wb, input string tag);
        drive(0, 0, 1, k, a, r, we, wd, wb, tag);
    endtask

    task automatic chk_sp(input logic [7:0] exp, input string tag);
        @(negedge clk);
        n_vec++;
        if (sp_out !== exp) begin
            n_bad++;
            $display("FAIL %s: sp_out %02h expected %02h", tag, sp_out, exp);
        end
    endtask

    // Monitor: pop the scoreboard each time a result appears.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_vec++;
            if (q_tag.size() == 0) begin
                n_bad++;
                $display("FAIL R10: unexpected result data %02h expected none", rd_data);
            end else begin
                logic [7:0] ed; logic eb, es; string t;
                ed = q_data.pop_front(); eb = q_bit.pop_front();
                es = q_sfr.pop_front(); t = q_tag.pop_front();
                if (rd_data !== ed || rd_bit !== eb || sfr_sel !== es) begin
                    n_bad++;
                    $display("FAIL %s: data %02h bit %b sfr %b expected %02h %b %b",
                             t, rd_data, rd_bit, sfr_sel, ed, eb, es);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: run incomplete, expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) m[i] = 8'h00;
        sp_m = 8'h07;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_vec++;
        if (rd_valid !== 1'b0) begin
            n_bad++; $display("FAIL R1: rd_valid %b expected 0", rd_valid);
        end
        rst_n = 1'b1;
        chk_sp(8'h07, "R1");
        acc(2'd1, 8'h10, 0, 0, 0, 0, "R1");
        // R2: same register number in two banks
        psw_in = 8'h00;
        acc(2'd0, 0, 3, 1, 8'hA3, 0, "R2");
        psw_in = 8'h10;
        acc(2'd0, 0, 3, 1, 8'h5C, 0, "R2");
        acc(2'd0, 0, 0, 1, 8'h90, 0, "R2");
        acc(2'd0, 0, 1, 1, 8'h45, 0, "R2");
        acc(2'd1, 8'h03, 0, 0, 0, 0, "R2");
        acc(2'd1, 8'h13, 0, 0, 0, 0, "R2");
        // R3: direct low half
        acc(2'd1, 8'h45, 0, 1, 8'h77, 0, "R3");
        acc(2'd1, 8'h45, 0, 0, 0, 0, "R3");
        acc(2'd1, 8'h7F, 0, 1, 8'hC1, 0, "R3");
        acc(2'd1, 8'h7F, 0, 0, 0, 0, "R3");
        // R4 / R5: upper half only through pointers
        acc(2'd1, 8'h90, 0, 1, 8'hEE, 0, "R4");
        acc(2'd2, 0, 0, 0, 0, 0, "R4");
        acc(2'd2, 0, 0, 1, 8'h3D, 0, "R5");
        acc(2'd2, 0, 0, 0, 0, 0, "R5");
        acc(2'd1, 8'h90, 0, 0, 0, 0, "R4");
        acc(2'd2, 0, 1, 0, 0, 0, "R5");
        psw_in = 8'h00;
        acc(2'd2, 0, 0, 0, 0, 0, "R5");
        // R6: bit window
        acc(2'd1, 8'h21, 0, 1, 8'hF0, 0, "R6");
        acc(2'd3, 8'h0B, 0, 1, 0, 1, "R6");
        acc(2'd1, 8'h21, 0, 0, 0, 0, "R6");
        acc(2'd3, 8'h0C, 0, 1, 0, 0, "R6");
        acc(2'd3, 8'h0C, 0, 0, 0, 0, "R6");
        acc(2'd3, 8'h0B, 0, 0, 0, 0, "R6");
        acc(2'd3, 8'h7F, 0, 1, 0, 1, "R6");
        acc(2'd1, 8'h2F, 0, 0, 0, 0, "R6");
        acc(2'd1, 8'h21, 0, 0, 0, 0, "R6");
        // R7: bit address in special-function space
        acc(2'd3, 8'h85, 0, 1, 0, 1, "R7");
        acc(2'd1, 8'h20, 0, 0, 0, 0, "R7");
        // R8: push
        drive(1, 0, 0, 0, 0, 0, 0, 8'h11, 0, "R8");
        drive(1, 0, 0, 0, 0, 0, 0, 8'h22, 0, "R8");
        chk_sp(8'h09, "R8");
        acc(2'd1, 8'h08, 0, 0, 0, 0, "R8");
        acc(2'd1, 8'h09, 0, 0, 0, 0, "R8");
        acc(2'd2, 0, 2, 0, 0, 0, "R5");
        // R9: pop and wrap
        drive(0, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
        chk_sp(8'h08, "R9");
        for (int i = 0; i < 9; i++) drive(0, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
        chk_sp(8'hFF, "R9");
        drive(1, 0, 0, 0, 0, 0, 0, 8'h5A, 0, "R9");
        chk_sp(8'h00, "R9");
        acc(2'd1, 8'h00, 0, 0, 0, 0, "R9");
        // R10: priority
        drive(1, 1, 1, 2'd1, 8'h40, 0, 1, 8'h99, 0, "R10");
        chk_sp(8'h01, "R10");
        acc(2'd1, 8'h40, 0, 0, 0, 0, "R10");
        drive(0, 1, 1, 2'd1, 8'h41, 0, 1, 8'h55, 0, "R10");
        chk_sp(8'h00, "R10");
        acc(2'd1, 8'h41, 0, 0, 0, 0, "R10");
        repeat (3) @(negedge clk);
        n_vec++;
        if (q_tag.size() != 0) begin
            n_bad++;
            $display("FAIL R10: %0d results missing expected 0", q_tag.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule